// File: doc/BRIEF.md
# Two-Step Flash Result Encoder

This block is the digital back end of a subranging converter. One comparator array of 33 comparators is sampled twice per conversion. The first sample is the coarse pass, taken against the 32-resistor string that spans the negative to the positive reference. The second is the fine pass, taken on the amplified residue. Each sample arrives as a thermometer word. The block turns each word into a 5-bit code and derives an over-range indication from the coarse pass. It collects both codes in a first-rank holding register. When the conversion ends, it copies a 10-bit two's-complement result and the over-range flag into a second-rank output register.

The sequencing logic drives three single-cycle strobes: coarse valid, fine valid and end of conversion. The outputs change only when end of conversion is strobed. Software or a bus interface can therefore read a stable word while the next conversion collects its passes.

Top module: `tsf_result_encoder`

## Requirements
- R1: While reset is asserted, and after it is released until the first end-of-conversion strobe, `result_o` is 0 and `ovr_o` is 0.
- R2: Let c be the length of the unbroken run of ones in the word counted upward from bit 0. On a coarse strobe with c from 1 to 32, the upper five bits of the offset-binary index become c-1.
- R3: Let f be the same run length for the word present on a fine strobe. The lower five bits of the index become f-1 for f from 1 to 32, 0 for f = 0, and 31 for f = 33.
- R4: Any bit above the first zero of the word is ignored. A set bit lying above a clear bit never changes the code.
- R5: For an in-range conversion, `result_o` equals the 10-bit index {coarse, fine} with bit 9 inverted. The result is two's complement: index 512 gives 0, 1023 gives 0x1FF and 0 gives 0x200.
- R6: A coarse word with all 33 bits set is positive over-range. At transfer, `ovr_o` = 1 and `result_o` = 0x1FF, whatever the fine pass held.
- R7: A coarse word with bit 0 clear is negative over-range. At transfer, `ovr_o` = 1 and `result_o` = 0x200, whatever the fine pass held.
- R8: `result_o` and `ovr_o` change only on the clock edge at which the end-of-conversion strobe is sampled. Coarse and fine strobes on their own leave the outputs unchanged.
- R9: An end-of-conversion strobe transfers the first-rank contents as they stood before that edge. A fine strobe in the same cycle reaches the outputs only at the next transfer.
- R10: When the coarse and fine strobes arrive in the same cycle, only the coarse pass is taken. The held fine code keeps its earlier value.
- R11: Each half of the first-rank register is held until its own strobe arrives. An end-of-conversion strobe with no new passes transfers the same word again. A later in-range coarse pass clears a held over-range.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| therm_i | input | 33 | Comparator thermometer word, bit 0 lowest tap |
| coarse_stb_i | input | 1 | Word holds the coarse pass this cycle |
| fine_stb_i | input | 1 | Word holds the fine pass this cycle |
| eoc_stb_i | input | 1 | End of conversion: transfer the first rank to the outputs |
| result_o | output | 10 | Two's-complement conversion result |
| ovr_o | output | 1 | Over-range flag; with result bit 9 it gives the direction |

## Verification
A wrong first-rank state is hidden until the next end-of-conversion strobe. It then shows at the ports one clock later, as a wrong upper or lower half of the result or as a flag without its saturated code. A miscounted run length moves the result by whole coarse steps of 32 or by single fine steps. That is why the coarse and fine run lengths are swept over every value, including the bubble patterns. A broken double-buffer path shows at once, because the outputs move on a cycle that carries no end-of-conversion strobe.

// File: rtl/tsf_pkg.sv
package tsf_pkg;

    // Default width of one flash pass; comparator count is 2**SUB_W + 1.
    localparam int unsigned DEF_SUB_W = 5;

    // Range classification of the coarse pass, held in the first rank.
    typedef enum logic [1:0] {
        RANGE_IN   = 2'd0,
        RANGE_HIGH = 2'd1,
        RANGE_LOW  = 2'd2
    } range_e;

endpackage

// File: rtl/tsf_run_length.sv
// Length of the unbroken run of ones from bit 0 upward (bubble suppression).
module tsf_run_length #(
    parameter int unsigned N  = 33,
    parameter int unsigned CW = $clog2(N + 1)
) (
    input  logic [N-1:0]  therm_i,
    output logic [CW-1:0] run_o
);

    logic [N-1:0] chain;

    assign chain[0] = therm_i[0];

    generate
        for (genvar i = 1; i < N; i++) begin : g_chain
            assign chain[i] = chain[i-1] & therm_i[i];
        end
    endgenerate

    always_comb begin
        run_o = '0;
        for (int i = 0; i < N; i++) begin
            run_o = run_o + CW'(chain[i]);
        end
    end

endmodule

// File: rtl/tsf_pass_encoder.sv
// Turns one run length into a coarse code with range and a clamped fine code.
module tsf_pass_encoder
    import tsf_pkg::*;
#(
    parameter int unsigned SUB_W = DEF_SUB_W,
    localparam int unsigned NCMP = (1 << SUB_W) + 1,
    localparam int unsigned CW   = $clog2(NCMP + 1)
) (
    input  logic [NCMP-1:0]  therm_i,
    output logic [SUB_W-1:0] coarse_code_o,
    output range_e           coarse_range_o,
    output logic [SUB_W-1:0] fine_code_o
);

    logic [CW-1:0] run;

    tsf_run_length #(.N(NCMP), .CW(CW)) u_run (
        .therm_i (therm_i),
        .run_o   (run)
    );

    localparam logic [CW-1:0] RUN_FULL = CW'(NCMP);

    always_comb begin
        if (run == RUN_FULL) begin
            coarse_range_o = RANGE_HIGH;
            coarse_code_o  = '1;
        end else if (run == '0) begin
            coarse_range_o = RANGE_LOW;
            coarse_code_o  = '0;
        end else begin
            coarse_range_o = RANGE_IN;
            coarse_code_o  = SUB_W'(run - CW'(1));
        end
    end

    always_comb begin
        if (run == '0) begin
            fine_code_o = '0;
        end else if (run == RUN_FULL) begin
            fine_code_o = '1;
        end else begin
            fine_code_o = SUB_W'(run - CW'(1));
        end
    end

endmodule

// File: rtl/tsf_word_builder.sv
// Joins the two passes, applies saturation and converts to two's complement.
module tsf_word_builder
    import tsf_pkg::*;
#(
    parameter int unsigned SUB_W = DEF_SUB_W,
    localparam int unsigned RES_W = 2 * SUB_W
) (
    input  logic [SUB_W-1:0] coarse_i,
    input  logic [SUB_W-1:0] fine_i,
    input  range_e           range_i,
    output logic [RES_W-1:0] data_o,
    output logic             ovr_o
);

    localparam logic [RES_W-1:0] POS_FULL = {1'b0, {(RES_W-1){1'b1}}};
    localparam logic [RES_W-1:0] NEG_FULL = {1'b1, {(RES_W-1){1'b0}}};

    logic [RES_W-1:0] index;

    assign index = {coarse_i, fine_i};

    always_comb begin
        unique case (range_i)
            RANGE_HIGH: begin
                data_o = POS_FULL;
                ovr_o  = 1'b1;
            end
            RANGE_LOW: begin
                data_o = NEG_FULL;
                ovr_o  = 1'b1;
            end
            default: begin
                data_o = {~index[RES_W-1], index[RES_W-2:0]};
                ovr_o  = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/tsf_result_encoder.sv
module tsf_result_encoder
    import tsf_pkg::*;
#(
    parameter int unsigned SUB_W = DEF_SUB_W,
    localparam int unsigned NCMP  = (1 << SUB_W) + 1,
    localparam int unsigned RES_W = 2 * SUB_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NCMP-1:0]  therm_i,
    input  logic             coarse_stb_i,
    input  logic             fine_stb_i,
    input  logic             eoc_stb_i,
    output logic [RES_W-1:0] result_o,
    output logic             ovr_o
);

    typedef struct packed {
        logic [SUB_W-1:0] coarse;
        logic [SUB_W-1:0] fine;
        range_e           range;
        logic [RES_W-1:0] res;
        logic             ovr;
    } state_t;

    localparam state_t STATE_RST = '{
        coarse: '0, fine: '0, range: RANGE_IN, res: '0, ovr: 1'b0
    };

    state_t state_d, state_q;

    logic [SUB_W-1:0] enc_coarse;
    logic [SUB_W-1:0] enc_fine;
    range_e           enc_range;
    logic [RES_W-1:0] built_data;
    logic             built_ovr;

    tsf_pass_encoder #(.SUB_W(SUB_W)) u_enc (
        .therm_i        (therm_i),
        .coarse_code_o  (enc_coarse),
        .coarse_range_o (enc_range),
        .fine_code_o    (enc_fine)
    );

    tsf_word_builder #(.SUB_W(SUB_W)) u_build (
        .coarse_i (state_q.coarse),
        .fine_i   (state_q.fine),
        .range_i  (state_q.range),
        .data_o   (built_data),
        .ovr_o    (built_ovr)
    );

    always_comb begin
        state_d = state_q;
        // First rank: the coarse pass wins when both strobes coincide.
        if (coarse_stb_i) begin
            state_d.coarse = enc_coarse;
            state_d.range  = enc_range;
        end else if (fine_stb_i) begin
            state_d.fine = enc_fine;
        end
        // Second rank: copies the first rank as it stood before this edge.
        if (eoc_stb_i) begin
            state_d.res = built_data;
            state_d.ovr = built_ovr;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= STATE_RST;
        end else begin
            state_q <= state_d;
        end
    end

    assign result_o = state_q.res;
    assign ovr_o    = state_q.ovr;

endmodule

// File: rtl/tsf_result_encoder_chk.sv
module tsf_result_encoder_chk
    import tsf_pkg::*;
#(
    parameter int unsigned NCMP  = 33,
    parameter int unsigned RES_W = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic [NCMP-1:0]  therm_i,
    input logic             coarse_stb_i,
    input logic             eoc_stb_i,
    input logic [RES_W-1:0] result_o,
    input logic             ovr_o,
    input range_e           r1_range
);

    localparam logic [RES_W-1:0] POS_FULL = {1'b0, {(RES_W-1){1'b1}}};
    localparam logic [RES_W-1:0] NEG_FULL = {1'b1, {(RES_W-1){1'b0}}};

    // R1
    always @(negedge clk) begin
        if (!rst_n) begin
            reset_out_zero_chk: assert (result_o == '0 && !ovr_o);
        end
    end

    // R8
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !eoc_stb_i |=> $stable(result_o) && $stable(ovr_o));

    // R6
    ovr_saturated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_o |-> (result_o == POS_FULL || result_o == NEG_FULL));

    // R6
    coarse_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        coarse_stb_i && (&therm_i) |=> r1_range == RANGE_HIGH);

    // R7
    coarse_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        coarse_stb_i && !therm_i[0] |=> r1_range == RANGE_LOW);

    // R9
    eoc_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eoc_stb_i |=> ovr_o == $past(r1_range != RANGE_IN));

    // R7
    low_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eoc_stb_i && r1_range == RANGE_LOW |=> ovr_o && result_o[RES_W-1]);

endmodule

bind tsf_result_encoder tsf_result_encoder_chk #(.NCMP(NCMP), .RES_W(RES_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .therm_i      (therm_i),
    .coarse_stb_i (coarse_stb_i),
    .eoc_stb_i    (eoc_stb_i),
    .result_o     (result_o),
    .ovr_o        (ovr_o),
    .r1_range     (state_q.range)
);

// File: tb/tb_tsf_result_encoder.sv
`timescale 1ns/1ps
module tb_tsf_result_encoder;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [32:0] therm = '0;
    logic        cstb = 1'b0, fstb = 1'b0, estb = 1'b0;
    logic [9:0]  result;
    logic        ovr;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    tsf_result_encoder dut (
        .clk(clk), .rst_n(rst_n), .therm_i(therm),
        .coarse_stb_i(cstb), .fine_stb_i(fstb), .eoc_stb_i(estb),
        .result_o(result), .ovr_o(ovr)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000 && !done) begin
            done = 1'b1;
            n_chk++; n_fail++;
            $display("FAIL watchdog: run did not end (actual cycle %0d, expected < 150000)", cyc);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    // Thermometer word: n low ones; optional stray one two places above the run.
    function automatic logic [32:0] word(int n, bit bubble);
        logic [32:0] w = '0;
        for (int i = 0; i < 33; i++) if (i < n) w[i] = 1'b1;
        if (bubble && n + 2 <= 32) w[n+2] = 1'b1;
        if (bubble && n == 0) w[5] = 1'b1;
        return w;
    endfunction

    function automatic int runlen(logic [32:0] w);
        int r = 0;
        for (int i = 0; i < 33; i++) begin
            if (w[i] && r == i) r++;
        end
        return r;
    endfunction

    function automatic int fine_of(int f);
        if (f == 0) return 0;
        if (f == 33) return 31;
        return f - 1;
    endfunction

    // Expected outputs from coarse run length and held fine code.
    task automatic expect_of(input int c, input int fc, output logic [9:0] r, output logic o);
        int idx;
        if (c == 33) begin r = 10'h1FF; o = 1'b1; end
        else if (c == 0) begin r = 10'h200; o = 1'b1; end
        else begin
            idx = (c - 1) * 32 + fc;
            r = 10'(idx) ^ 10'h200;
            o = 1'b0;
        end
    endtask

    task automatic step(input logic [32:0] t, input logic c, input logic f, input logic e);
        @(negedge clk);
        therm = t; cstb = c; fstb = f; estb = e;
    endtask

    task automatic check(input string tag, input logic [9:0] er, input logic eo);
        n_chk++;
        if (result !== er || ovr !== eo) begin
            n_fail++;
            $display("FAIL %s: actual result=%h ovr=%b expected result=%h ovr=%b",
                     tag, result, ovr, er, eo);
        end
    endtask

    task automatic convert(input logic [32:0] cw, input logic [32:0] fw);
        step(cw, 1, 0, 0);
        step(fw, 0, 1, 0);
        step('0, 0, 0, 1);
        step('0, 0, 0, 0);
    endtask

    initial begin
        logic [9:0] er;
        logic       eo;
        int held_c, held_f;

        repeat (3) @(negedge clk);
        check("R1 in reset", 10'h000, 1'b0);
        rst_n = 1'b1;
        step('1, 1, 0, 0);
        step('1, 0, 1, 0);
        step('0, 0, 0, 0);
        check("R1 after release, no eoc", 10'h000, 1'b0);

        // R2: coarse sweep with fixed fine run of 1
        for (int c = 1; c <= 32; c++) begin
            convert(word(c, 0), word(1, 0));
            expect_of(c, 0, er, eo);
            check("R2 coarse sweep", er, eo);
        end

        // R3: fine sweep over every run length with a mid coarse code
        for (int f = 0; f <= 33; f++) begin
            convert(word(16, 0), word(f, 0));
            expect_of(16, fine_of(f), er, eo);
            check("R3 fine sweep", er, eo);
        end

        // R4: bubbles in both passes
        for (int n = 0; n <= 31; n++) begin
            convert(word(n, 1), word(n, 1));
            expect_of(runlen(word(n, 1)), fine_of(runlen(word(n, 1))), er, eo);
            check("R4 bubble", er, eo);
        end

        // R5/R6/R7: exhaustive coarse x fine run lengths
        for (int c = 0; c <= 33; c++) begin
            for (int f = 0; f <= 33; f++) begin
                convert(word(c, 0), word(f, 0));
                expect_of(c, fine_of(f), er, eo);
                if (c == 33) check("R6 positive over-range", er, eo);
                else if (c == 0) check("R7 negative over-range", er, eo);
                else check("R5 two's complement", er, eo);
            end
        end

        // R5 boundary codes
        convert(word(17, 0), word(1, 0));
        check("R5 zero code", 10'h000, 1'b0);
        convert(word(32, 0), word(32, 0));
        check("R5 positive full scale", 10'h1FF, 1'b0);
        convert(word(1, 0), word(1, 0));
        check("R5 negative full scale", 10'h200, 1'b0);
        convert(word(16, 0), word(32, 0));
        check("R5 one below zero", 10'h3FF, 1'b0);

        // R8: passes without eoc leave outputs alone
        convert(word(10, 0), word(20, 0));
        expect_of(10, 19, er, eo);
        step(word(25, 0), 1, 0, 0);
        step(word(3, 0), 0, 1, 0);
        step('0, 0, 0, 0);
        step('0, 0, 0, 0);
        check("R8 no eoc hold", er, eo);
        held_c = 25; held_f = 2;

        // R11: bare eoc transfers the held word
        step('0, 0, 0, 1);
        step('0, 0, 0, 0);
        expect_of(held_c, held_f, er, eo);
        check("R11 held transfer", er, eo);
        step('0, 0, 0, 1);
        step('0, 0, 0, 0);
        check("R11 repeated transfer", er, eo);

        // R9: fine strobe together with eoc is not in this transfer
        step(word(5, 0), 1, 0, 0);
        step(word(30, 0), 0, 1, 1);
        step('0, 0, 0, 0);
        expect_of(5, held_f, er, eo);
        check("R9 same-cycle fine excluded", er, eo);
        step('0, 0, 0, 1);
        step('0, 0, 0, 0);
        expect_of(5, 29, er, eo);
        check("R9 fine appears at next transfer", er, eo);

        // R10: coarse and fine together, fine ignored
        step(word(12, 0), 1, 1, 0);
        step('0, 0, 0, 1);
        step('0, 0, 0, 0);
        expect_of(12, 29, er, eo);
        check("R10 coarse wins", er, eo);

        // R11: in-range coarse clears a held over-range
        convert('1, word(7, 0));
        check("R11 over-range set", 10'h1FF, 1'b1);
        step(word(20, 0), 1, 0, 0);
        step('0, 0, 0, 1);
        step('0, 0, 0, 0);
        expect_of(20, 6, er, eo);
        check("R11 over-range cleared", er, eo);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule